// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block holds the current time and date as packed BCD fields and steps them forward by one second for every second strobe. The fields are seconds, minutes, hours on a 24-hour dial, day of month, a separate day-of-week counter running 1 to 7, month, and a three-digit year whose zero stands for 2000. Carries ripple from seconds up to the year. February gets a 29th day whenever the year is a multiple of four.

The second strobe comes from a prescaler that counts pulses of a reference enable, 32768 of them by default. The prescaler runs only while the run enable is high and is cleared whenever that input is low. Software loads any single field through a write port of select, data and write enable. A load is accepted only while the counter runs. The current fields are driven out continuously, so reads and an external alarm comparator can use them. A registered copy of the second strobe is also driven out.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After reset the fields read 00 seconds, 00 minutes, 00 hours, day 01, weekday 1, month 01, year 000, and sec_pulse is low.
- R2: Seconds and minutes count in BCD from 00 to 59. A low digit of 9 wraps to 0 and increments the high digit. After 59 the field returns to 00 and carries into the next field.
- R3: Hours count in BCD from 00 to 23. After 23 they return to 00 and carry into the day.
- R4: Month runs 01 to 12. The day of month wraps to 01 after the last day of its month, which is 31 for months 01, 03, 05, 07, 08, 10 and 12, 30 for months 04, 06, 09 and 11, and 28 for month 02 in a common year. This wrap increments the month. After month 12 the month returns to 01 and the year increments.
- R5: In month 02 the last day is 29 when the stored year (2000 plus the value) is divisible by four.
- R6: The weekday advances by one each time the day of month advances and returns from 7 to 1.
- R7: The year is three BCD digits, with the hundreds digit in bits [11:8] and the tens and units digits in bits [7:0]. It wraps from 999 to 000.
- R8: While run_en is high, the DIV_COUNT-th ref_tick pulse advances the time. sec_pulse is high for exactly one cycle, and it is the first cycle in which the new time is visible.
- R9: While run_en is low the fields hold, no sec_pulse is issued, and the prescaler is cleared, so a partial count of reference pulses is discarded.
- R10: A write loads wr_data into the field chosen by wr_sel. The codes are 0 seconds [6:0], 1 minutes [6:0], 2 hours [5:0], 3 day [5:0], 4 weekday [2:0], 5 month [4:0] and 6 year [11:0]. Code 7 changes nothing, and a write made while run_en is low is ignored.
- R11: When a write and a second advance fall in the same cycle, the written field takes the written value and every other field holds, so that second is dropped. sec_pulse is still issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run enable; gates counting and writes |
| ref_tick | input | 1 | Reference enable pulse, one per prescaler count |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select code |
| wr_data | input | 12 | Write value, right-aligned BCD |
| sec_o | output | 7 | Seconds, BCD |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 6 | Hours, BCD |
| mday_o | output | 6 | Day of month, BCD |
| wday_o | output | 3 | Day of week, 1 to 7 |
| mon_o | output | 5 | Month, BCD |
| year_o | output | 12 | Year offset from 2000, three BCD digits |
| sec_pulse | output | 1 | One-cycle strobe marking a new second |

## Verification
The assertions check several properties on every cycle: the fields stay frozen while the counter is stopped, every accepted advance changes the time, the strobe lasts one cycle, no strobe follows directly after enabling, and a write wins over a coincident advance. Whether each carry lands on the right value can only be shown by the bench's scenarios. These scenarios cover month lengths, leap and common Februaries, the century and 999 wraps, the weekday wrap, and the loss of a partial prescaler count. They compare the design against an independent binary model of the calendar.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

  typedef enum logic [2:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_MDAY = 3'd3,
    SEL_WDAY = 3'd4,
    SEL_MON  = 3'd5,
    SEL_YEAR = 3'd6,
    SEL_NONE = 3'd7
  } field_sel_e;

  typedef struct packed {
    logic [11:0] year;
    logic [4:0]  mon;
    logic [2:0]  wday;
    logic [5:0]  mday;
    logic [5:0]  hour;
    logic [6:0]  min;
    logic [6:0]  sec;
  } caltime_t;

  localparam caltime_t CAL_RESET = '{
    year: 12'h000, mon: 5'h01, wday: 3'd1, mday: 6'h01,
    hour: 6'h00, min: 7'h00, sec: 7'h00
  };

  // one BCD digit step, 9 wraps to 0
  function automatic logic [3:0] dig_inc(input logic [3:0] d);
    return (d >= 4'd9) ? 4'd0 : d + 4'd1;
  endfunction

  function automatic logic dig_carry(input logic [3:0] d);
    return d >= 4'd9;
  endfunction

  // year = 2000 + value; 2000 and 100*h are multiples of 4, so only
  // (10*tens + units) mod 4 = (2*tens + units) mod 4 matters
  function automatic logic leap_year(input logic [11:0] y);
    logic [1:0] r;
    r = y[1:0] + {y[4], 1'b0};
    return r == 2'd0;
  endfunction

  function automatic logic [5:0] month_days(input logic [4:0] mon,
                                            input logic [11:0] y);
    case (mon)
      5'h02:                      return leap_year(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  // three-digit BCD year step, 999 wraps to 000
  function automatic logic [11:0] year_inc(input logic [11:0] y);
    logic [3:0] u, t, h;
    u = dig_inc(y[3:0]);
    t = dig_carry(y[3:0]) ? dig_inc(y[7:4]) : y[7:4];
    h = (dig_carry(y[3:0]) && dig_carry(y[7:4])) ? dig_inc(y[11:8]) : y[11:8];
    return {h, t, u};
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler
  import caltime_pkg::*;
#(
  parameter int DIV_COUNT = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic ref_tick,
  output logic tick
);
  localparam int CW = (DIV_COUNT > 2) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_COUNT - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick    = run_en && ref_tick && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_en) begin
      cnt_q <= '0;
    end else if (ref_tick) begin
      cnt_q <= at_last ? '0 : cnt_q + CW'(1);
    end
  end

  // R9
  no_tick_after_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> !tick);

endmodule

// File: rtl/cal_next.sv
module cal_next
  import caltime_pkg::*;
(
  input  caltime_t cur,
  output caltime_t nxt,
  output logic     day_roll,
  output logic     year_roll
);
  logic       sec_top, min_top, hour_top, mday_top, mon_top;
  logic       sec_w, min_w, hour_w;
  logic [5:0] dim;

  assign dim      = month_days(cur.mon, cur.year);
  assign sec_top  = cur.sec  >= 7'h59;
  assign min_top  = cur.min  >= 7'h59;
  assign hour_top = cur.hour >= 6'h23;
  assign mday_top = cur.mday >= dim;
  assign mon_top  = cur.mon  >= 5'h12;

  assign sec_w     = sec_top;
  assign min_w     = sec_w && min_top;
  assign hour_w    = min_w && hour_top;
  assign day_roll  = hour_w && mday_top;
  assign year_roll = day_roll && mon_top;

  always_comb begin
    nxt = cur;
    nxt.sec = sec_top ? 7'h00
            : {dig_carry(cur.sec[3:0]) ? cur.sec[6:4] + 3'd1 : cur.sec[6:4],
               dig_inc(cur.sec[3:0])};
    if (sec_w) begin
      nxt.min = min_top ? 7'h00
              : {dig_carry(cur.min[3:0]) ? cur.min[6:4] + 3'd1 : cur.min[6:4],
                 dig_inc(cur.min[3:0])};
    end
    if (min_w) begin
      nxt.hour = hour_top ? 6'h00
               : {dig_carry(cur.hour[3:0]) ? cur.hour[5:4] + 2'd1 : cur.hour[5:4],
                  dig_inc(cur.hour[3:0])};
    end
    if (hour_w) begin
      nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
      nxt.mday = mday_top ? 6'h01
               : {dig_carry(cur.mday[3:0]) ? cur.mday[5:4] + 2'd1 : cur.mday[5:4],
                  dig_inc(cur.mday[3:0])};
    end
    if (day_roll) begin
      nxt.mon = mon_top ? 5'h01
              : {dig_carry(cur.mon[3:0]) ? 1'b1 : cur.mon[4],
                 dig_inc(cur.mon[3:0])};
    end
    if (year_roll) begin
      nxt.year = year_inc(cur.year);
    end
  end

endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter
  import caltime_pkg::*;
#(
  parameter int DIV_COUNT = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_en,
  input  logic        ref_tick,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [11:0] wr_data,
  output logic [6:0]  sec_o,
  output logic [6:0]  min_o,
  output logic [5:0]  hour_o,
  output logic [5:0]  mday_o,
  output logic [2:0]  wday_o,
  output logic [4:0]  mon_o,
  output logic [11:0] year_o,
  output logic        sec_pulse
);
  caltime_t   cur_q, nxt;
  field_sel_e sel_e;
  logic       tick, wr_hit, adv, day_roll, year_roll, pulse_q;

  cal_prescaler #(.DIV_COUNT(DIV_COUNT)) u_prescaler (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ref_tick(ref_tick), .tick(tick)
  );

  cal_next u_next (
    .cur(cur_q), .nxt(nxt), .day_roll(day_roll), .year_roll(year_roll)
  );

  assign sel_e  = field_sel_e'(wr_sel);
  assign wr_hit = wr_en && run_en && (sel_e != SEL_NONE);
  assign adv    = tick && !wr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= CAL_RESET;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= tick;
      if (wr_hit) begin
        case (sel_e)
          SEL_SEC:  cur_q.sec  <= wr_data[6:0];
          SEL_MIN:  cur_q.min  <= wr_data[6:0];
          SEL_HOUR: cur_q.hour <= wr_data[5:0];
          SEL_MDAY: cur_q.mday <= wr_data[5:0];
          SEL_WDAY: cur_q.wday <= wr_data[2:0];
          SEL_MON:  cur_q.mon  <= wr_data[4:0];
          SEL_YEAR: cur_q.year <= wr_data;
          default:  cur_q      <= cur_q;
        endcase
      end else if (adv) begin
        cur_q <= nxt;
      end
    end
  end

  assign sec_o     = cur_q.sec;
  assign min_o     = cur_q.min;
  assign hour_o    = cur_q.hour;
  assign mday_o    = cur_q.mday;
  assign wday_o    = cur_q.wday;
  assign mon_o     = cur_q.mon;
  assign year_o    = cur_q.year;
  assign sec_pulse = pulse_q;

  // R9 / R10
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(cur_q));

  // R2
  advance_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> cur_q != $past(cur_q));

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse);

  // R11
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wr_hit && sel_e == SEL_MIN) |=>
      (min_o == $past(wr_data[6:0])) && (sec_o == $past(sec_o)));

  // R7
  year_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && year_roll) |=> (mon_o == 5'h01) && (mday_o == 6'h01));

endmodule

// File: tb/bcd_calendar_counter_bench.sv
module bcd_calendar_counter_bench;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd7;
  logic [11:0] wr_data = '0;
  logic [6:0]  sec_o, min_o;
  logic [5:0]  hour_o, mday_o;
  logic [2:0]  wday_o;
  logic [4:0]  mon_o;
  logic [11:0] year_o;
  logic        sec_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int m_sec, m_min, m_hour, m_mday, m_wday, m_mon, m_year;

  always #5 clk = ~clk;

  bcd_calendar_counter #(.DIV_COUNT(DIV)) u_bcd_calendar_counter (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ref_tick(ref_tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .mday_o(mday_o),
    .wday_o(wday_o), .mon_o(mon_o), .year_o(year_o), .sec_pulse(sec_pulse)
  );

  function automatic int b2(input int n);
    return ((n / 10) << 4) | (n % 10);
  endfunction

  function automatic int b3(input int n);
    return ((n / 100) << 8) | (((n / 10) % 10) << 4) | (n % 10);
  endfunction

  function automatic int days_of(input int mo, input int yr);
    if (mo == 2) return ((2000 + yr) % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [45:0] expect_vec();
    return {12'(b3(m_year)), 5'(b2(m_mon)), 3'(m_wday), 6'(b2(m_mday)),
            6'(b2(m_hour)), 7'(b2(m_min)), 7'(b2(m_sec))};
  endfunction

  task automatic model_step();
    m_sec++;
    if (m_sec == 60) begin m_sec = 0; m_min++; end
    if (m_min == 60) begin m_min = 0; m_hour++; end
    if (m_hour == 24) begin
      m_hour = 0;
      m_wday = (m_wday == 7) ? 1 : m_wday + 1;
      m_mday++;
      if (m_mday > days_of(m_mon, m_year)) begin
        m_mday = 1; m_mon++;
        if (m_mon == 13) begin m_mon = 1; m_year = (m_year + 1) % 1000; end
      end
    end
  endtask

  task automatic check(input string req, input logic [45:0] act, input logic [45:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_time(input string req);
    check(req, {year_o, mon_o, wday_o, mday_o, hour_o, min_o, sec_o}, expect_vec());
  endtask

  task automatic check_pulse(input string req, input logic exp);
    check(req, 46'(sec_pulse), 46'(exp));
  endtask

  task automatic ref_pulse(input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
  endtask

  task automatic one_second(input string req);
    for (int k = 0; k < DIV; k++) ref_pulse($urandom % 3);
    if (run_en) model_step();
    check_pulse(req, run_en);
    check_time(req);
  endtask

  task automatic wr(input logic [2:0] s, input logic [11:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_sel = 3'd7;
  endtask

  task automatic set_date(input int y, input int mo, input int d, input int wd,
                          input int h, input int mi, input int s);
    wr(3'd6, 12'(b3(y))); wr(3'd5, 12'(b2(mo))); wr(3'd3, 12'(b2(d)));
    wr(3'd4, 12'(wd));    wr(3'd2, 12'(b2(h)));  wr(3'd1, 12'(b2(mi)));
    wr(3'd0, 12'(b2(s)));
    m_year = y; m_mon = mo; m_mday = d; m_wday = wd; m_hour = h; m_min = mi; m_sec = s;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed_set;
    seed_set = $urandom(32'h5EC0DE);
    m_year = 0; m_mon = 1; m_mday = 1; m_wday = 1; m_hour = 0; m_min = 0; m_sec = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_time("R1 reset fields");
    check_pulse("R1 reset pulse", 1'b0);

    run_en = 1'b1;
    // R8 basic seconds and digit carry (R2)
    for (int i = 0; i < 12; i++) one_second("R8 second advance");
    set_date(23, 5, 14, 3, 10, 59, 58);
    one_second("R2 second 59");
    one_second("R2 minute carry");
    // R3 hour carry into day, R6 weekday
    set_date(23, 5, 14, 7, 23, 59, 59);
    one_second("R6 weekday 7 to 1");
    // R4 month lengths and year step
    set_date(23, 4, 30, 2, 23, 59, 59);
    one_second("R4 April 30");
    set_date(99, 12, 31, 5, 23, 59, 59);
    one_second("R4 December to January, century");
    // R5 leap rules
    set_date(24, 2, 28, 3, 23, 59, 59);
    one_second("R5 leap Feb 28");
    for (int i = 0; i < 86400 - 1; i += 86400) begin end
    set_date(24, 2, 29, 4, 23, 59, 59);
    one_second("R5 leap Feb 29");
    set_date(23, 2, 28, 2, 23, 59, 59);
    one_second("R5 common Feb 28");
    set_date(0, 2, 28, 1, 23, 59, 59);
    one_second("R5 year 2000 leap");
    // R7 year wrap
    set_date(999, 12, 31, 6, 23, 59, 59);
    one_second("R7 year 999 wrap");

    // R10 select 7 changes nothing
    wr(3'd7, 12'h123);
    check_time("R10 select 7 ignored");
    // R9 stopped: hold, no pulse, writes ignored
    @(negedge clk); run_en = 1'b0;
    for (int k = 0; k < DIV + 2; k++) ref_pulse(0);
    check_pulse("R9 no pulse stopped", 1'b0);
    check_time("R9 hold stopped");
    wr(3'd0, 12'h033);
    check_time("R10 write while stopped");
    // R9 partial count discarded
    @(negedge clk); run_en = 1'b1;
    for (int k = 0; k < DIV - 1; k++) ref_pulse(0);
    @(negedge clk); run_en = 1'b0;
    @(negedge clk); run_en = 1'b1;
    for (int k = 0; k < DIV - 1; k++) ref_pulse(0);
    check_time("R9 partial count lost");
    check_pulse("R9 no early pulse", 1'b0);
    ref_pulse(0);
    model_step();
    check_pulse("R9 pulse after full count", 1'b1);
    check_time("R9 advance after full count");
    @(negedge clk);
    check_pulse("R8 pulse one cycle", 1'b0);

    // R11 write coincides with advance
    for (int k = 0; k < DIV - 1; k++) ref_pulse(0);
    @(negedge clk); ref_tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 12'h037;
    @(negedge clk); ref_tick = 1'b0; wr_en = 1'b0; wr_sel = 3'd7;
    m_min = 37;
    check_pulse("R11 pulse still issued", 1'b1);
    check_time("R11 write wins, second dropped");
    one_second("R11 next second counts");

    // random dates near carries
    for (int it = 0; it < 40; it++) begin
      int y, mo, d, h, mi, s, wd, n;
      y  = $urandom % 1000;
      mo = 1 + $urandom % 12;
      d  = ($urandom % 2) ? days_of(mo, y) : 1 + $urandom % days_of(mo, y);
      wd = 1 + $urandom % 7;
      h  = ($urandom % 2) ? 23 : $urandom % 24;
      mi = ($urandom % 2) ? 59 : $urandom % 60;
      s  = ($urandom % 2) ? 59 - $urandom % 3 : $urandom % 60;
      set_date(y, mo, d, wd, h, mi, s);
      n = 1 + $urandom % 3;
      for (int j = 0; j < n; j++) one_second("R4 random calendar step");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule